// File: doc/BRIEF.md
# Read Wait-State Generator for a Processor Ready Line

This block drives the ready line of an 8-bit processor bus so that a read from a slow memory region is given one extra bus cycle. Every clock edge at which the bus-cycle strobe is high and ready is high starts a new access. If that access reads the slow region (the active-high region select is 1), ready is held low for the next cycle. The processor holds its state during that cycle, so the access takes two bus cycles instead of one.

Writes cannot be stalled. When a write hits the slow region, the request is stored in a deferred-stall flag and no wait state is given. The next read that is started then receives the single wait state, whatever region it targets, and the flag is cleared. While ready is low, the inputs are not sampled. Ready always comes back high in the cycle after the wait state.

Top module: `rdy_wait_ctrl`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, ready is 1 after that edge and any deferred stall is discarded. A fast read started right after reset gets no wait state.
- R2: An access starts at an edge where the bus-cycle strobe is 1 and ready is 1. If that access is a read (write strobe 0) and the region select is 1, ready is 0 during the following cycle.
- R3: Ready is never 0 for two cycles in a row. The wait state is exactly one cycle long.
- R4: An access started with the write strobe at 1 never makes ready 0 in the following cycle, whatever the region select is.
- R5: A write started with the region select at 1 records a deferred stall. The next read that is started gets one wait state even if its region select is 0, and the stall is then cleared.
- R6: With no deferred stall pending, a read started with the region select at 0 leaves ready at 1.
- R7: A cycle with the bus-cycle strobe at 0 leaves ready at 1 and keeps a pending deferred stall unchanged.
- R8: The write strobe and region select are ignored during the wait-state cycle. A slow write presented while ready is 0 records no deferred stall, and a later fast read gets no wait state.
- R9: Back-to-back slow reads each receive exactly one wait state.
- R10: Several slow writes before a read collapse into one deferred stall. Only the first following read waits, and the read after it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | A bus cycle is presented in this clock |
| is_write | input | 1 | 1 = write cycle, 0 = read cycle |
| slow_sel | input | 1 | Address decode of the slow region, active high |
| rdy_o | output | 1 | Registered ready line to the processor; 0 = wait state |

## Verification
The bench targets four cases:

- **Slow write followed by a fast read.** A design that applies the stall at once would drop ready after the write. A design that forgets the stall would let the read through unstretched.
- **Back-to-back slow reads.** A design that does not return ready high after one cycle would give the second read a double or merged wait.
- **Slow write during the wait cycle.** A design that samples inputs while stalled would record a spurious deferred stall.
- **Idle gaps between a slow write and its read, and repeated slow writes.** These catch a flag that is cleared by idle cycles, or a counter that stacks several waits.

// File: rtl/rdy_wait_pkg.sv
package rdy_wait_pkg;
  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } rdy_state_e;

  typedef struct packed {
    logic accept;
    logic rd_start;
    logic wr_slow;
    logic rd_slow;
  } acc_kind_t;
endpackage

// File: rtl/rdy_acc_classify.sv
module rdy_acc_classify
  import rdy_wait_pkg::*;
(
  input  logic      cyc_valid,
  input  logic      is_write,
  input  logic      slow_sel,
  input  logic      rdy_now,
  output acc_kind_t kind
);
  always_comb begin
    kind.accept   = cyc_valid & rdy_now;
    kind.rd_start = kind.accept & ~is_write;
    kind.wr_slow  = kind.accept & is_write & slow_sel;
    kind.rd_slow  = kind.rd_start & slow_sel;
  end
endmodule

// File: rtl/rdy_defer_flag.sv
module rdy_defer_flag
  import rdy_wait_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  acc_kind_t kind,
  output logic      pend
);
  always_ff @(posedge clk) begin
    if (rst)               pend <= 1'b0;
    else if (kind.wr_slow) pend <= 1'b1;
    else if (kind.rd_start) pend <= 1'b0;
  end
endmodule

// File: rtl/rdy_stretch.sv
module rdy_stretch
  import rdy_wait_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  acc_kind_t kind,
  input  logic      pend,
  output logic      rdy
);
  rdy_state_e state_q, state_d;

  always_comb begin
    state_d = ST_RUN;
    if (state_q == ST_RUN && kind.rd_start && (kind.rd_slow || pend))
      state_d = ST_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign rdy = (state_q == ST_RUN);
endmodule

// File: rtl/rdy_wait_ctrl.sv
module rdy_wait_ctrl
  import rdy_wait_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cyc_valid,
  input  logic is_write,
  input  logic slow_sel,
  output logic rdy_o
);
  acc_kind_t kind;
  logic      pend;
  logic      rdy_q;

  rdy_acc_classify u_cls (
    .cyc_valid (cyc_valid),
    .is_write  (is_write),
    .slow_sel  (slow_sel),
    .rdy_now   (rdy_q),
    .kind      (kind)
  );

  rdy_defer_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .kind (kind),
    .pend (pend)
  );

  rdy_stretch u_str (
    .clk  (clk),
    .rst  (rst),
    .kind (kind),
    .pend (pend),
    .rdy  (rdy_q)
  );

  assign rdy_o = rdy_q;
endmodule

// File: rtl/rdy_wait_ctrl_chk.sv
module rdy_wait_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cyc_valid,
  input logic is_write,
  input logic slow_sel,
  input logic rdy_o,
  input logic pend
);
  // R1
  reset_ready_chk: assert property (@(posedge clk) rst |=> (rdy_o && !pend));

  // R2
  slow_read_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && cyc_valid && !is_write && slow_sel) |=> !rdy_o);

  // R3
  single_wait_chk: assert property (@(posedge clk) disable iff (rst)
    !rdy_o |=> rdy_o);

  // R4
  write_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && cyc_valid && is_write) |=> rdy_o);

  // R5
  defer_record_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && cyc_valid && is_write && slow_sel) |=> pend);

  // R5
  defer_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && cyc_valid && !is_write && pend) |=> (!rdy_o && !pend));

  // R6
  fast_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && cyc_valid && !is_write && !slow_sel && !pend) |=> rdy_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rdy_o && !cyc_valid) |=> (rdy_o && $stable(pend)));

  // R8
  wait_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !rdy_o |=> $stable(pend));
endmodule

bind rdy_wait_ctrl rdy_wait_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_valid (cyc_valid),
  .is_write  (is_write),
  .slow_sel  (slow_sel),
  .rdy_o     (rdy_o),
  .pend      (pend)
);

// File: tb/rdy_wait_ctrl_tb_top.sv
module rdy_wait_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_valid = 1'b0;
  logic is_write = 1'b0;
  logic slow_sel = 1'b0;
  logic rdy_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state, valid after the next rising edge
  logic exp_rdy = 1'b1;
  logic exp_pend = 1'b0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  rdy_wait_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .cyc_valid (cyc_valid),
    .is_write  (is_write),
    .slow_sel  (slow_sel),
    .rdy_o     (rdy_o)
  );

  function automatic logic [1:0] model_next(logic r, logic p, logic rs,
                                            logic v, logic w, logic s);
    logic nr, np;
    nr = 1'b1;
    np = p;
    if (rs) begin
      nr = 1'b1;
      np = 1'b0;
    end else if (!r) begin
      nr = 1'b1;
    end else if (v) begin
      if (w) np = p | s;
      else if (s || p) begin
        nr = 1'b0;
        np = 1'b0;
      end
    end
    return {nr, np};
  endfunction

  function automatic string auto_tag(logic r, logic p, logic v, logic w, logic s);
    if (!r) return "R3";
    if (!v) return "R7";
    if (w) return "R4";
    if (p) return "R5";
    if (s) return "R2";
    return "R6";
  endfunction

  task automatic check_out();
    n_tests++;
    if (rdy_o !== exp_rdy) begin
      n_fail++;
      $display("FAIL %s: rdy_o actual=%b expected=%b at %0t", cur_tag, rdy_o, exp_rdy, $time);
    end
  endtask

  // drive one cycle at the falling edge, check at the next falling edge
  task automatic step(logic rs, logic v, logic w, logic s, string tag);
    logic [1:0] nx;
    rst = rs;
    cyc_valid = v;
    is_write = w;
    slow_sel = s;
    cur_tag = (tag == "") ? auto_tag(exp_rdy, exp_pend, v, w, s) : tag;
    nx = model_next(exp_rdy, exp_pend, rs, v, w, s);
    @(negedge clk);
    exp_rdy = nx[1];
    exp_pend = nx[0];
    check_out();
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    @(negedge clk);
    step(1, 0, 0, 0, "R1");
    step(1, 1, 1, 1, "R1");
    step(0, 1, 0, 0, "R1");
    // R2 / R3: slow read then return high
    step(0, 1, 0, 1, "R2");
    step(0, 1, 0, 1, "R3");
    step(0, 1, 0, 0, "R6");
    // R9: back-to-back slow reads
    step(0, 1, 0, 1, "R9");
    step(0, 1, 0, 1, "R9");
    step(0, 1, 0, 1, "R9");
    step(0, 1, 0, 1, "R9");
    // R4 / R5: slow write defers to a fast read
    step(0, 1, 1, 1, "R4");
    step(0, 1, 0, 0, "R5");
    step(0, 1, 0, 0, "R5");
    step(0, 1, 0, 0, "R6");
    // R7: idle cycles keep the deferred stall
    step(0, 1, 1, 1, "R4");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 1, 0, "R7");
    step(0, 1, 0, 0, "R7");
    step(0, 1, 0, 0, "R7");
    // R10: repeated slow writes give one wait only
    step(0, 1, 1, 1, "R10");
    step(0, 1, 1, 1, "R10");
    step(0, 1, 1, 0, "R10");
    step(0, 1, 0, 0, "R10");
    step(0, 1, 0, 0, "R10");
    step(0, 1, 0, 0, "R10");
    // R8: slow write presented during wait state is ignored
    step(0, 1, 0, 1, "R8");
    step(0, 1, 1, 1, "R8");
    step(0, 1, 0, 0, "R8");
    step(0, 1, 0, 0, "R8");
    // R1: reset discards a pending stall
    step(0, 1, 1, 1, "R1");
    step(1, 0, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic rs;
      rs = ($urandom % 200) == 0;
      step(rs, ($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 2) == 0, "");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule